// File: doc/BRIEF.md
# Reloadable Baud Tick Generator

This block divides the system clock down to a strobe at sixteen times the serial bit rate. A down-counter of `WIDTH` bits runs from a programmable reload value. Each time it expires it raises `tick_o` for exactly one clock and starts over. A transmitter and a receiver share the strobe as their oversampling enable. For a reload value N, the bit rate is f_clk / (16 · N).

The host side is a single register-style port. A write stores a new reload value and restarts the count from that value at once. A read returns the live counter, not the stored reload value. The `run_i` input freezes and releases the count. A write made while the count is frozen is remembered. The restart it asks for happens on the first clock on which `run_i` is high.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `rd_data_o` reads 0 and `tick_o` is low.
- R2: While `run_i` is 1 and no write or restart is due, a counter above 1 falls by exactly 1 per clock, and `rd_data_o` shows that value.
- R3: With reload value N ≥ 1 and `run_i` held at 1, `tick_o` pulses once every N clocks. Expiry happens on the clock where the counter is 1 (or 0). On that clock the counter reloads to N, and `tick_o` goes high in the following cycle.
- R4: A reload value of 0 acts as a period of 1: a tick in every cycle, with `rd_data_o` staying at 0.
- R5: A write with `run_i` = 1 stores `wr_data_i` as the reload value, and `rd_data_o` shows that value in the next cycle.
- R6: A write with `run_i` = 0 leaves the counter untouched. On the first clock with `run_i` = 1, the counter loads the latest written value, and no tick comes from that clock.
- R7: While `run_i` is 0, the counter holds its value and no tick is produced. When `run_i` returns to 1, counting resumes from the held value.
- R8: If a write falls on the same clock as an expiry, the write takes effect and no tick comes from that clock.
- R9: Every tick is exactly one cycle wide when N ≥ 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 = count, 0 = freeze |
| wr_en_i | input | 1 | Write strobe for a new reload value |
| wr_data_i | input | WIDTH | Reload value to write |
| rd_data_o | output | WIDTH | Live counter value |
| tick_o | output | 1 | One-cycle strobe at sixteen times the bit rate |

## Verification
The bench builds the block with `WIDTH` = 16 and the registered tick variant. These defaults let it write the all-ones value and watch the counter step down from the top of the range. Short reload values (0, 1, 2, 5, 7) keep every period within a few cycles. That brings within reach back-to-back ticks, a write landing exactly on an expiry, and deferred loads after writes made while frozen. A scoreboard queues the cycle number of every expected tick and compares each observed tick against it.

// File: rtl/bdg_pkg.sv
package bdg_pkg;

   // what the counter does on the coming clock edge
   typedef enum logic [2:0] {
      ACT_HOLD      = 3'd0,
      ACT_DEC       = 3'd1,
      ACT_WRITE     = 3'd2,
      ACT_LATE_LOAD = 3'd3,
      ACT_EXPIRE    = 3'd4
   } cnt_act_e;

   function automatic logic act_loads_reload(input cnt_act_e a);
      return (a == ACT_LATE_LOAD) || (a == ACT_EXPIRE);
   endfunction

endpackage

// File: rtl/bdg_ctrl.sv
module bdg_ctrl
   import bdg_pkg::*;
(
   input  logic     run_i,
   input  logic     wr_en_i,
   input  logic     late_pend_i,
   input  logic     cnt_low_i,
   output cnt_act_e act_o,
   output logic     expire_o
);

   // priority: write while running, freeze, deferred load, expiry, count
   always_comb begin
      if (wr_en_i && run_i)      act_o = ACT_WRITE;
      else if (!run_i)           act_o = ACT_HOLD;
      else if (late_pend_i)      act_o = ACT_LATE_LOAD;
      else if (cnt_low_i)        act_o = ACT_EXPIRE;
      else                       act_o = ACT_DEC;
   end

   assign expire_o = (act_o == ACT_EXPIRE);

endmodule

// File: rtl/bdg_reload_reg.sv
module bdg_reload_reg #(
   parameter int WIDTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             wr_en_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic [WIDTH-1:0] reload_o,
   output logic             late_pend_o
);

   logic [WIDTH-1:0] reload_q;
   logic             pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reload_q <= '0;
      end else if (wr_en_i) begin
         reload_q <= wr_data_i;
      end
   end

   // a write while frozen leaves a restart owed to the counter
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
      end else if (wr_en_i && !run_i) begin
         pend_q <= 1'b1;
      end else if (run_i) begin
         pend_q <= 1'b0;
      end
   end

   assign reload_o    = reload_q;
   assign late_pend_o = pend_q;

   p_pend_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !run_i) |=> late_pend_o);

   p_pend_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |=> !late_pend_o);

endmodule

// File: rtl/bdg_down_counter.sv
module bdg_down_counter
   import bdg_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  cnt_act_e         act_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic [WIDTH-1:0] reload_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             cnt_low_o
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         unique case (act_i)
            ACT_WRITE:               cnt_q <= wr_data_i;
            ACT_LATE_LOAD,
            ACT_EXPIRE:              cnt_q <= reload_i;
            ACT_DEC:                 cnt_q <= cnt_q - ONE;
            default:                 cnt_q <= cnt_q;
         endcase
      end
   end

   // 0 or 1 counts as expired: a zero reload gives a period of one clock
   assign cnt_low_o = (cnt_q[WIDTH-1:1] == '0);
   assign cnt_o     = cnt_q;

   p_reload_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_loads_reload(act_i) |=> cnt_o == $past(reload_i));

endmodule

// File: rtl/bdg_tick_out.sv
module bdg_tick_out #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic expire_i,
   output logic tick_o
);

   generate
      if (REGISTERED) begin : g_reg
         logic tick_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) tick_q <= 1'b0;
            else         tick_q <= expire_i;
         end
         assign tick_o = tick_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk_i ^ rst_ni;
         assign tick_o     = expire_i;
      end
   endgenerate

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import bdg_pkg::*;
#(
   parameter int WIDTH           = 16,
   parameter bit TICK_REGISTERED = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             wr_en_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic             tick_o
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("baud_tick_gen: WIDTH must lie in 2..32");
      end
   endgenerate

   cnt_act_e         act;
   logic             expire;
   logic             late_pend;
   logic             cnt_low;
   logic [WIDTH-1:0] reload;
   logic [WIDTH-1:0] cnt;

   bdg_reload_reg #(.WIDTH(WIDTH)) i_reload (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_i),
      .wr_en_i     (wr_en_i),
      .wr_data_i   (wr_data_i),
      .reload_o    (reload),
      .late_pend_o (late_pend)
   );

   bdg_ctrl i_ctrl (
      .run_i       (run_i),
      .wr_en_i     (wr_en_i),
      .late_pend_i (late_pend),
      .cnt_low_i   (cnt_low),
      .act_o       (act),
      .expire_o    (expire)
   );

   bdg_down_counter #(.WIDTH(WIDTH)) i_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act),
      .wr_data_i (wr_data_i),
      .reload_i  (reload),
      .cnt_o     (cnt),
      .cnt_low_o (cnt_low)
   );

   bdg_tick_out #(.REGISTERED(TICK_REGISTERED)) i_tick (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .expire_i (expire),
      .tick_o   (tick_o)
   );

   assign rd_data_o = cnt;

   p_hold_stopped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> $stable(rd_data_o));

   p_load_on_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && wr_en_i) |=> rd_data_o == $past(wr_data_i));

   p_step_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !wr_en_i && !late_pend && rd_data_o > ONE)
      |=> rd_data_o == $past(rd_data_o) - ONE);

   p_late_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !wr_en_i && late_pend) |=> rd_data_o == $past(reload));

   generate
      if (TICK_REGISTERED) begin : g_tick_chk
         p_no_tick_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !run_i |=> !tick_o);

         p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_en_i |=> !tick_o);

         p_expiry_ticks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (run_i && !wr_en_i && !late_pend && rd_data_o <= ONE) |=> tick_o);

         p_single_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tick_o && rd_data_o > ONE) |=> !tick_o);
      end
   endgenerate

endmodule

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         run;
   logic         wr_en;
   logic [W-1:0] wr_data;
   logic [W-1:0] rd_data;
   logic         tick;

   always #2 clk = ~clk;

   baud_tick_gen #(.WIDTH(W), .TICK_REGISTERED(1'b1)) i_baud_tick_gen (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .run_i     (run),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .rd_data_o (rd_data),
      .tick_o    (tick)
   );

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;
   int exp_q[$];
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: every observed tick must match the head of the expected queue
   always @(negedge clk) begin
      if (rst_n && tick) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3 R9 unexpected tick", cyc, -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(e == cyc, "R3 tick cycle", cyc, e);
         end
      end
   end

   // driver: write at a falling edge, return the cycle number of the capturing edge
   task automatic do_write(input logic [W-1:0] v, input bit r, output int e);
      wr_en   = 1'b1;
      wr_data = v;
      run     = r;
      @(negedge clk);
      wr_en = 1'b0;
      e = cyc;
   endtask

   // queue k ticks for reload n loaded at edge e, check the live count until the k-th
   task automatic track(input int e, input int n, input int k);
      int p;
      p = (n == 0) ? 1 : n;
      for (int i = 1; i <= k; i++) exp_q.push_back(e + i * p);
      forever begin
         int x;
         x = (n == 0) ? 0 : n - ((cyc - e) % n);
         chk(rd_data == W'(x), "R2 R4 live count", rd_data, x);
         if (cyc >= e + k * p) break;
         @(negedge clk);
      end
   endtask

   task automatic stop_and_hold();
      logic [W-1:0] v;
      v   = rd_data;
      run = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(rd_data == v, "R7 count held", rd_data, v);
         chk(tick == 1'b0, "R7 no tick while frozen", tick, 0);
      end
      chk(exp_q.size() == 0, "R3 missing ticks", exp_q.size(), 0);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int e;
      rst_n   = 1'b0;
      run     = 1'b0;
      wr_en   = 1'b0;
      wr_data = '0;
      repeat (3) @(negedge clk);
      chk(rd_data == 0, "R1 count in reset", rd_data, 0);
      chk(tick == 0, "R1 tick in reset", tick, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data == 0, "R1 count after reset", rd_data, 0);
      chk(tick == 0, "R1 tick after reset", tick, 0);

      // R6: write while frozen, load deferred to first running clock
      do_write(W'(5), 1'b0, e);
      for (int i = 0; i < 3; i++) begin
         chk(rd_data == 0, "R6 frozen write leaves count", rd_data, 0);
         @(negedge clk);
      end
      run = 1'b1;
      @(negedge clk);
      e = cyc;
      chk(tick == 0, "R6 no tick on deferred load", tick, 0);
      chk(rd_data == 5, "R6 deferred load value", rd_data, 5);
      track(e, 5, 3);

      // R8: write lands on the expiry clock
      for (int j = 1; j <= 4; j++) begin
         @(negedge clk);
         chk(rd_data == W'(5 - j), "R2 count down", rd_data, 5 - j);
      end
      do_write(W'(2), 1'b1, e);
      chk(tick == 0, "R8 write beats expiry", tick, 0);
      chk(rd_data == 2, "R5 write while running", rd_data, 2);
      track(e, 2, 5);

      // R4: zero reload
      do_write(W'(0), 1'b1, e);
      chk(rd_data == 0, "R5 R4 zero written", rd_data, 0);
      track(e, 0, 6);

      // period of one
      do_write(W'(1), 1'b1, e);
      chk(rd_data == 1, "R5 one written", rd_data, 1);
      track(e, 1, 4);
      stop_and_hold();

      // R6: two frozen writes, the latest one is loaded
      do_write(W'(16'hFFFF), 1'b0, e);
      do_write(W'(7), 1'b0, e);
      chk(rd_data == 1, "R6 frozen writes leave count", rd_data, 1);
      run = 1'b1;
      @(negedge clk);
      e = cyc;
      chk(tick == 0, "R6 no tick on deferred load", tick, 0);
      chk(rd_data == 7, "R6 latest frozen write loaded", rd_data, 7);
      track(e, 7, 3);
      stop_and_hold();

      // R5: full-range value, R7: resume from held count
      do_write(W'(16'hFFFF), 1'b1, e);
      chk(rd_data == 16'hFFFF, "R5 full-range write", rd_data, 16'hFFFF);
      @(negedge clk);
      chk(rd_data == 16'hFFFE, "R2 step from top", rd_data, 16'hFFFE);
      @(negedge clk);
      chk(rd_data == 16'hFFFD, "R2 step from top", rd_data, 16'hFFFD);
      stop_and_hold();
      run = 1'b1;
      @(negedge clk);
      chk(rd_data == 16'hFFFC, "R7 resume from held count", rd_data, 16'hFFFC);
      stop_and_hold();

      done = 1'b1;
      summary();
      $finish;
   end

endmodule